// File: doc/BRIEF.md
# Descriptor Ring Pointer Manager

This block keeps the pointer state of a single descriptor queue held in shared memory: a start address, a ring size, a pointer owned by software and a pointer owned by the hardware side. Descriptors are 32 bytes each. Both pointers are kept as descriptor indices but are read and written over the register port as byte offsets. From the two pointers the block derives the occupancy of the ring and four status flags: empty, full, almost-empty and almost-full. The two almost flags are compared against thresholds that software programs.

A DMA engine pulses the advance strobe once per descriptor it handles. It reads the byte address of the descriptor it should touch next from the hardware address output. A parameter selects the direction of the queue. As a consumer queue, software produces descriptors by moving the write index, and the hardware moves the read index. As a producer queue, the hardware fills descriptors by moving the write index, and software returns them by moving the read index. The count register reports valid descriptors for a consumer queue and free descriptors for a producer queue.

Three configuration fields are protected by a gate word. Software sets the gate bit for a field, writes the field, and then clears the gate word. A write to a protected field is dropped while its gate bit is clear.

Top module: `ring_ptr_mgr`

## Requirements
- R1: After reset the start address is 0, the ring size is 2^IDX_W, both indices are 0, the almost-empty threshold is 0, the almost-full threshold is 2^IDX_W-1 and the gate word is 0. The flags read empty=1, full=0, almost-empty=1 and almost-full=0.
- R2: The register map is word 0 start address, word 1 ring size, word 2 software pointer, word 3 hardware pointer (read only), word 4 count (read only), word 5 almost-empty threshold, word 6 almost-full threshold and word 7 gate word. A write to word 0 needs gate bit 2, a write to word 1 needs gate bit 1 and a write to word 2 needs gate bit 0. Without its gate bit, the write leaves the field unchanged.
- R3: Pointer words carry byte offsets. A write to the software pointer takes the index from data bits [IDX_W+4:5] and ignores bits [4:0]. Pointer reads return the index shifted left by 5.
- R4: Indices wrap modulo the programmed ring size, which must be a power of two. The index after size-1 is 0, and software pointer writes are masked to the ring size.
- R5: Let valid = (write index - read index) mod size. Word 4 returns valid on a consumer queue and size-1-valid on a producer queue.
- R6: The empty flag is high exactly when valid is 0.
- R7: The full flag is high exactly when valid equals size-1, so one slot always stays unused.
- R8: The almost-empty flag is high when valid is at or below the almost-empty threshold. The almost-full flag is high when valid is at or above the almost-full threshold.
- R9: An advance strobe moves the hardware index by one. The strobe is ignored while the queue is empty on a consumer queue, or while it is full on a producer queue.
- R10: The hardware address output equals the start address plus 32 times the hardware index.
- R11: The thresholds and the gate word are written without any gate and read back what was written.
- R12: A software pointer write and an accepted advance in the same cycle both take effect, and the flags that follow reflect both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word select |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data for the selected word (combinational) |
| hwAdv | input | 1 | Hardware advance strobe, one descriptor per cycle |
| hwAddr | output | ADDR_W | Byte address of the descriptor at the hardware index |
| qEmpty | output | 1 | No valid descriptors |
| qFull | output | 1 | Valid count equals size-1 |
| qAlmostEmpty | output | 1 | Valid count at or below the almost-empty threshold |
| qAlmostFull | output | 1 | Valid count at or above the almost-full threshold |

## Verification
Software can move its pointer in the same clock in which the DMA side pulses the advance strobe. The new occupancy then has to account for both moves at once, and the gate that blocks an advance on an empty or full queue must be judged on the occupancy from before that edge. The bench provokes this with one cycle in which a gated pointer write and the advance strobe are raised together, on a consumer queue and a producer queue side by side. It compares both queues' flags and hardware addresses against a behavioural model on every clock, and then reads back both pointers and the count.

// File: rtl/ringq_pkg.sv
package ringq_pkg;
  localparam int DESC_SHIFT = 5;  // 32-byte descriptors
  localparam int GATE_SWPTR = 0;
  localparam int GATE_DEPTH = 1;
  localparam int GATE_START = 2;

  typedef enum logic [2:0] {
    SEL_START = 3'd0,
    SEL_DEPTH = 3'd1,
    SEL_SWPTR = 3'd2,
    SEL_HWPTR = 3'd3,
    SEL_COUNT = 3'd4,
    SEL_AETH  = 3'd5,
    SEL_AFTH  = 3'd6,
    SEL_GATE  = 3'd7
  } regSel_e;

  typedef struct packed {
    logic ldStart;
    logic ldDepth;
    logic ldSwPtr;
    logic ldAeTh;
    logic ldAfTh;
  } ringStrobe_t;
endpackage

// File: rtl/ringq_ctrl.sv
module ringq_ctrl
  import ringq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [2:0]        regAddr,
  input  logic [2:0]        gateWrData,
  input  logic [ADDR_W-1:0] viewStart,
  input  logic [IDX_W:0]    viewDepth,
  input  logic [IDX_W-1:0]  viewSwIdx,
  input  logic [IDX_W-1:0]  viewHwIdx,
  input  logic [IDX_W:0]    viewCount,
  input  logic [IDX_W:0]    viewAeTh,
  input  logic [IDX_W:0]    viewAfTh,
  output ringStrobe_t       strobe,
  output logic [31:0]       regRdData
);
  logic [2:0] gateReg;
  regSel_e    sel;

  assign sel = regSel_e'(regAddr);

  // Decode register writes; three fields also need their gate bit
  always_comb begin
    strobe         = '0;
    strobe.ldStart = regWr && (sel == SEL_START) && gateReg[GATE_START];
    strobe.ldDepth = regWr && (sel == SEL_DEPTH) && gateReg[GATE_DEPTH];
    strobe.ldSwPtr = regWr && (sel == SEL_SWPTR) && gateReg[GATE_SWPTR];
    strobe.ldAeTh  = regWr && (sel == SEL_AETH);
    strobe.ldAfTh  = regWr && (sel == SEL_AFTH);
  end

  always_ff @(posedge clk) begin
    if (!rstN) gateReg <= '0;
    else if (regWr && (sel == SEL_GATE)) gateReg <= gateWrData;
  end

  always_comb begin
    case (sel)
      SEL_START: regRdData = 32'(viewStart);
      SEL_DEPTH: regRdData = 32'(viewDepth);
      SEL_SWPTR: regRdData = 32'(viewSwIdx) << DESC_SHIFT;
      SEL_HWPTR: regRdData = 32'(viewHwIdx) << DESC_SHIFT;
      SEL_COUNT: regRdData = 32'(viewCount);
      SEL_AETH:  regRdData = 32'(viewAeTh);
      SEL_AFTH:  regRdData = 32'(viewAfTh);
      default:   regRdData = 32'(gateReg);
    endcase
  end

  AST_GATE_START: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == 3'd0 && !gateReg[GATE_START]) |-> !strobe.ldStart); // R2
  AST_GATE_DEPTH: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == 3'd1 && !gateReg[GATE_DEPTH]) |-> !strobe.ldDepth); // R2
endmodule

// File: rtl/ringq_dpath.sv
module ringq_dpath
  import ringq_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int IDX_W       = 10,
  parameter bit HW_PRODUCER = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  ringStrobe_t       strobe,
  input  logic [31:0]       wrData,
  input  logic              hwAdv,
  output logic [ADDR_W-1:0] startOut,
  output logic [IDX_W:0]    depthOut,
  output logic [IDX_W-1:0]  swIdxOut,
  output logic [IDX_W-1:0]  hwIdxOut,
  output logic [IDX_W:0]    countOut,
  output logic [IDX_W:0]    aeThOut,
  output logic [IDX_W:0]    afThOut,
  output logic [ADDR_W-1:0] hwAddr,
  output logic              emptyFlag,
  output logic              fullFlag,
  output logic              almostEmpty,
  output logic              almostFull
);
  localparam int CNT_W = IDX_W + 1;
  localparam logic [CNT_W-1:0] DEPTH_RST = CNT_W'(1) << IDX_W;
  localparam logic [CNT_W-1:0] AFTH_RST  = DEPTH_RST - CNT_W'(1);

  logic [ADDR_W-1:0] startReg;
  logic [CNT_W-1:0]  depthReg, aeThReg, afThReg;
  logic [IDX_W-1:0]  swIdxReg, hwIdxReg;
  logic [IDX_W-1:0]  wrIdx, rdIdx, idxMask;
  logic [CNT_W-1:0]  depthM1, validCnt;
  logic              hwGo;

  assign depthM1  = depthReg - CNT_W'(1);
  assign idxMask  = depthM1[IDX_W-1:0];
  assign validCnt = {1'b0, (wrIdx - rdIdx) & idxMask};

  assign emptyFlag   = (validCnt == '0);
  assign fullFlag    = (validCnt == depthM1);
  assign almostEmpty = (validCnt <= aeThReg);
  assign almostFull  = (validCnt >= afThReg);

  // Direction picks which pointer the hardware owns and what count reports
  generate
    if (HW_PRODUCER) begin : g_prod
      assign wrIdx    = hwIdxReg;
      assign rdIdx    = swIdxReg;
      assign hwGo     = hwAdv & ~fullFlag;
      assign countOut = depthM1 - validCnt;
      AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rstN)
        (hwAdv && fullFlag) |=> $stable(hwIdxReg)); // R9
    end else begin : g_cons
      assign wrIdx    = swIdxReg;
      assign rdIdx    = hwIdxReg;
      assign hwGo     = hwAdv & ~emptyFlag;
      assign countOut = validCnt;
      AST_NO_UNDERRUN: assert property (@(posedge clk) disable iff (!rstN)
        (hwAdv && emptyFlag) |=> $stable(hwIdxReg)); // R9
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startReg <= '0;
      depthReg <= DEPTH_RST;
      aeThReg  <= '0;
      afThReg  <= AFTH_RST;
      swIdxReg <= '0;
      hwIdxReg <= '0;
    end else begin
      if (strobe.ldStart) startReg <= wrData[ADDR_W-1:0];
      if (strobe.ldDepth) depthReg <= wrData[CNT_W-1:0];
      if (strobe.ldAeTh)  aeThReg  <= wrData[CNT_W-1:0];
      if (strobe.ldAfTh)  afThReg  <= wrData[CNT_W-1:0];
      if (strobe.ldSwPtr)
        swIdxReg <= wrData[IDX_W+DESC_SHIFT-1:DESC_SHIFT] & idxMask;
      if (hwGo) hwIdxReg <= (hwIdxReg + IDX_W'(1)) & idxMask;
    end
  end

  assign hwAddr   = startReg + (ADDR_W'(hwIdxReg) << DESC_SHIFT);
  assign startOut = startReg;
  assign depthOut = depthReg;
  assign swIdxOut = swIdxReg;
  assign hwIdxOut = hwIdxReg;
  assign aeThOut  = aeThReg;
  assign afThOut  = afThReg;

  AST_SW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.ldSwPtr |=> $stable(swIdxReg)); // R2
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    (depthReg > CNT_W'(1)) |-> !(emptyFlag && fullFlag)); // R7
endmodule

// File: rtl/ring_ptr_mgr.sv
module ring_ptr_mgr
  import ringq_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int IDX_W       = 10,
  parameter bit HW_PRODUCER = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [2:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              hwAdv,
  output logic [ADDR_W-1:0] hwAddr,
  output logic              qEmpty,
  output logic              qFull,
  output logic              qAlmostEmpty,
  output logic              qAlmostFull
);
  localparam int CNT_W = IDX_W + 1;

  ringStrobe_t       strobe;
  logic [ADDR_W-1:0] startV;
  logic [CNT_W-1:0]  depthV, countV, aeV, afV;
  logic [IDX_W-1:0]  swV, hwV;

  ringq_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) uCtrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .gateWrData(regWrData[2:0]),
    .viewStart(startV), .viewDepth(depthV), .viewSwIdx(swV), .viewHwIdx(hwV),
    .viewCount(countV), .viewAeTh(aeV), .viewAfTh(afV),
    .strobe(strobe), .regRdData(regRdData)
  );

  ringq_dpath #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .HW_PRODUCER(HW_PRODUCER)) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(regWrData), .hwAdv(hwAdv),
    .startOut(startV), .depthOut(depthV), .swIdxOut(swV), .hwIdxOut(hwV),
    .countOut(countV), .aeThOut(aeV), .afThOut(afV), .hwAddr(hwAddr),
    .emptyFlag(qEmpty), .fullFlag(qFull),
    .almostEmpty(qAlmostEmpty), .almostFull(qAlmostFull)
  );
endmodule

// File: tb/sim_ring_ptr_mgr.sv
module sim_ring_ptr_mgr;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [31:0] regWrData = 32'd0;
  logic        hwAdv = 1'b0;
  logic [31:0] rdD [2];
  logic [31:0] hAd [2];
  logic        eO [2];
  logic        fO [2];
  logic        aeO [2];
  logic        afO [2];

  int nChk = 0;
  int nBad = 0;
  bit done = 0;

  // behavioural model state
  int mStart, mDepth, mAe, mAf, mGate;
  int mSw [2];
  int mHw [2];

  always #2 clk = ~clk;  // 250 MHz

  ring_ptr_mgr #(.HW_PRODUCER(1'b0)) u0 (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(rdD[0]), .hwAdv(hwAdv), .hwAddr(hAd[0]), .qEmpty(eO[0]), .qFull(fO[0]),
    .qAlmostEmpty(aeO[0]), .qAlmostFull(afO[0]));

  ring_ptr_mgr #(.HW_PRODUCER(1'b1)) u1 (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(rdD[1]), .hwAdv(hwAdv), .hwAddr(hAd[1]), .qEmpty(eO[1]), .qFull(fO[1]),
    .qAlmostEmpty(aeO[1]), .qAlmostFull(afO[1]));

  function automatic int mValid(input int i);
    int w, r;
    w = (i == 0) ? mSw[i] : mHw[i];
    r = (i == 0) ? mHw[i] : mSw[i];
    return (w - r) & (mDepth - 1);
  endfunction

  function automatic logic [31:0] mRead(input int i, input int a);
    case (a)
      0: return mStart;
      1: return mDepth;
      2: return mSw[i] << 5;
      3: return mHw[i] << 5;
      4: return (i == 0) ? mValid(i) : (mDepth - 1 - mValid(i));
      5: return mAe;
      6: return mAf;
      default: return mGate;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mStart = 0; mDepth = 1024; mAe = 0; mAf = 1023; mGate = 0;
      for (int i = 0; i < 2; i++) begin mSw[i] = 0; mHw[i] = 0; end
    end else begin
      int nh [2];
      for (int i = 0; i < 2; i++) begin
        int v;
        bit go;
        v  = mValid(i);
        go = hwAdv && ((i == 0) ? (v != 0) : (v != mDepth - 1));
        nh[i] = go ? ((mHw[i] + 1) & (mDepth - 1)) : mHw[i];
      end
      if (regWr) begin
        case (regAddr)
          3'd0: if (mGate[2]) mStart = regWrData;
          3'd1: if (mGate[1]) mDepth = regWrData & 'h7FF;
          3'd2: if (mGate[0]) for (int i = 0; i < 2; i++)
                  mSw[i] = (regWrData >> 5) & (mDepth - 1);
          3'd5: mAe = regWrData & 'h7FF;
          3'd6: mAf = regWrData & 'h7FF;
          default: if (regAddr == 3'd7) mGate = regWrData & 7;
        endcase
      end
      for (int i = 0; i < 2; i++) mHw[i] = nh[i];
    end
  end

  task automatic cmp(input string tag, input int i, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s u%0d %s: actual %0h expected %0h", tag, i, what, act, exp);
    end
  endtask

  // per-clock comparison of flags and hardware address
  always @(negedge clk) begin
    if (rstN && !done) begin
      for (int i = 0; i < 2; i++) begin
        int v;
        v = mValid(i);
        cmp("R6", i, "empty", 32'(eO[i]), 32'(v == 0));
        cmp("R7", i, "full", 32'(fO[i]), 32'(v == mDepth - 1));
        cmp("R8", i, "almostEmpty", 32'(aeO[i]), 32'(v <= mAe));
        cmp("R8", i, "almostFull", 32'(afO[i]), 32'(v >= mAf));
        cmp("R10", i, "hwAddr", hAd[i], 32'(mStart + (mHw[i] << 5)));
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); regWr = 1'b1; regAddr = 3'(a); regWrData = d;
    @(negedge clk); regWr = 1'b0;
  endtask

  task automatic gatedWr(input int a, input int bitPos, input logic [31:0] d);
    wr(7, 32'(1 << bitPos));
    wr(a, d);
    wr(7, 32'd0);
  endtask

  task automatic rdChk(input int a, input string tag);
    @(negedge clk); regAddr = 3'(a); #1;
    for (int i = 0; i < 2; i++) cmp(tag, i, $sformatf("word%0d", a), rdD[i], mRead(i, a));
  endtask

  task automatic adv(input int n);
    @(negedge clk); hwAdv = 1'b1;
    repeat (n) @(negedge clk);
    hwAdv = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    for (int a = 0; a < 8; a++) rdChk(a, "R1");          // R1 reset values
    wr(2, 32'h0000_00A0);                                 // R2 no gate bit 0
    wr(0, 32'h1234_0000);                                 // R2 no gate bit 2
    wr(1, 32'd16);                                        // R2 no gate bit 1
    rdChk(2, "R2"); rdChk(0, "R2"); rdChk(1, "R2");
    gatedWr(2, 0, (32'd5 << 5) | 32'h1F);                 // R3 junk low bits
    rdChk(2, "R3"); rdChk(4, "R5");
    gatedWr(1, 1, 32'd8);                                 // ring size 8
    rdChk(1, "R4"); rdChk(4, "R5");
    wr(5, 32'd2); wr(6, 32'd6);                           // R11 ungated
    rdChk(5, "R11"); rdChk(6, "R11"); rdChk(7, "R11");
    gatedWr(0, 2, 32'h1000_0000);                         // R10 base
    rdChk(0, "R10");
    adv(8);                                               // R9 stops at empty/full
    rdChk(3, "R9"); rdChk(4, "R9");
    gatedWr(2, 0, 32'd2 << 5);
    adv(7);                                               // R4 wrap past 7
    rdChk(3, "R4"); rdChk(4, "R5");
    gatedWr(2, 0, 32'd1 << 5);                            // consumer full
    rdChk(4, "R7");
    wr(7, 32'd1);
    @(negedge clk); regWr = 1'b1; regAddr = 3'd2; regWrData = 32'd3 << 5; hwAdv = 1'b1;
    @(negedge clk); regWr = 1'b0; hwAdv = 1'b0;          // R12 same cycle
    wr(7, 32'd0);
    rdChk(2, "R12"); rdChk(3, "R12"); rdChk(4, "R12");
    adv(3);
    rdChk(3, "R12"); rdChk(4, "R5");
    repeat (2) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    #400000;
    nChk++; nBad++;
    $display("FAIL watchdog: actual running expected finished");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule